// File: doc/BRIEF.md
# Unlock-Cycle Flash Bank Eraser and Programmer

This controller erases or programs one bank of a byte-wide flash device that uses the unlock-cycle command set. Before every command it writes two fixed unlock cycles to fixed offsets in the bank. After every erase or byte program it waits for the device to finish. It does this by reading the bank base address twice and checking whether a status bit toggled between the two reads. Each wait has an iteration limit, and a wait that reaches the limit ends the operation with a timeout.

The host issues one command at a time on a valid/ready command channel. To program, the host streams the bank image one byte per transfer on a valid/ready image channel, starting at offset 0. The controller raises `img_ready` only when it is ready for the next byte. A byte is taken only in a cycle where `img_valid` and `img_ready` are both high. If `img_valid` is low, the controller waits and puts nothing on the flash bus. Once `img_valid` is raised, the host must hold it and `img_data` until the byte is taken.

The result comes back on a valid/ready response channel and stays there until the host accepts it. If an operation ends early, the image bytes that were not taken are never requested, and the host drops them. After an erase, the controller reads every byte of the bank and requires each to be erased. During programming, it reads each byte back as soon as that byte completes and compares it with the image.

Top module: `flashprog_ctrl`

## Requirements
- R1: After reset, and while `rst_n` is low: `cmd_ready`=1, `rsp_valid`=0, `img_ready`=0, `fl_we`=0 and `fl_re`=0.
- R2: Every command burst begins with two unlock writes: data 0xAA to offset 0x555, then data 0x55 to offset 0x2AA. The first write cycle of any burst is therefore always 0xAA at 0x555.
- R3: An erase (`cmd_op`=0) writes exactly these six cycles in order: unlock, 0x80 to 0x555, unlock, then 0x30 to offset 0. Each erase command produces exactly one erase on the device.
- R4: A program (`cmd_op`=1) writes each byte as four cycles: unlock, 0xA0 to 0x555, then the image byte to its target offset. Target offsets run from 0 up to BANK_BYTES-1 in order, and the write burst for a byte starts in the cycle after that byte is accepted.
- R5: Completion polling reads offset 0 twice, with at least one idle cycle between any two reads. The device is busy when bit 6 of the XOR of the two values is 1. The controller never writes, and never reads any address other than offset 0, while the device is busy. `fl_we` and `fl_re` are never high together.
- R6: If the (POLL_LIMIT+1)-th consecutive read pair in one wait still shows busy, the operation ends with status 1 (timeout). That wait has made exactly 2*(POLL_LIMIT+1) reads.
- R7: After an erase completes, every offset from 0 to BANK_BYTES-1 must read 0xFF. Any other value ends the operation with status 2 (verify failure), and this includes the last offset.
- R8: After each byte completes, its offset is read back and compared with the image byte. A mismatch ends the operation at once with status 2, and no further image bytes are requested.
- R9: An operation that completes and verifies returns status 0. For a program, the bank then holds the image exactly.
- R10: After a command is accepted, `cmd_ready` stays low until the response is taken. `rsp_valid` and `rsp_status` are held steady while `rsp_ready` is low.
- R11: One image byte is taken per program burst. Gaps in `img_valid` only delay programming and do not change its result. While no byte is offered, no flash write happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle, command accepted when valid |
| cmd_op | input | 1 | 0 = erase bank, 1 = program bank |
| img_valid | input | 1 | Image byte offered |
| img_ready | output | 1 | Controller wants the next image byte |
| img_data | input | 8 | Image byte for the next offset |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Host takes the result |
| rsp_status | output | 2 | 0 ok, 1 timeout, 2 verify failure |
| fl_addr | output | ADDR_W (13) | Flash bank offset |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write strobe, one cycle per write |
| fl_re | output | 1 | Flash read strobe; data returns on `fl_rdata` the next cycle |
| fl_rdata | input | 8 | Flash read data |

## Verification
The bench pairs the controller with a behavioural flash model. The model decodes the unlock command set, toggles bit 6 while busy, and can never raise a programmed bit. It flags any write out of sequence, any write while busy, any back-to-back read, and any program offset that is not the next one in order. A wrong unlock address or data value, or a missing gap between reads, shows up as a model protocol error. An off-by-one in the poll counter shows up as a wrong read count on a device that never stops toggling.

An erase fault is placed on the last offset, so a verify loop that stops one byte early returns status 0 instead of 2. A program fault is placed on offset 0, so a design that defers its checks, or skips the first byte, reports the wrong status. Image gaps and a mid-operation reset with no image offered confirm that a starved or reset controller leaves the bus quiet and then recovers.

// File: rtl/flashprog_pkg.sv
package flashprog_pkg;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_TIMEOUT = 2'd1,
    ST_VERIFY  = 2'd2
  } status_e;

  typedef enum logic {
    OP_ERASE   = 1'b0,
    OP_PROGRAM = 1'b1
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_ER_CMD, S_ER_WAIT, S_EV_RD, S_EV_CHK,
    S_PG_FETCH, S_PG_CMD, S_PG_WAIT, S_PG_RD, S_PG_CHK, S_RESP
  } state_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RD1, PH_CAP1, PH_RD2, PH_CMP
  } phase_e;

  localparam logic [11:0] KEY_ADDR_A = 12'h555;
  localparam logic [11:0] KEY_ADDR_B = 12'h2AA;
  localparam logic [7:0]  KEY_DATA_A = 8'hAA;
  localparam logic [7:0]  KEY_DATA_B = 8'h55;
  localparam logic [7:0]  OPC_ERASE_ARM  = 8'h80;
  localparam logic [7:0]  OPC_ERASE_GO   = 8'h30;
  localparam logic [7:0]  OPC_BYTE_WRITE = 8'hA0;
  localparam logic [7:0]  BLANK_BYTE     = 8'hFF;
  localparam int          TOGGLE_BIT     = 6;

endpackage

// File: rtl/flashprog_cmdseq.sv
module flashprog_cmdseq
  import flashprog_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_prog,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [7:0]        tgt_data,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        wdata,
  output logic              done
);

  localparam logic [2:0] LAST_PROG  = 3'd3;
  localparam logic [2:0] LAST_ERASE = 3'd5;
  localparam logic [ADDR_W-1:0] A_KEY1 = ADDR_W'(KEY_ADDR_A);
  localparam logic [ADDR_W-1:0] A_KEY2 = ADDR_W'(KEY_ADDR_B);

  logic              busy_q;
  logic              prog_q;
  logic [2:0]        step_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [2:0]        last_step;

  assign last_step = prog_q ? LAST_PROG : LAST_ERASE;
  assign we        = busy_q;
  assign done      = busy_q && (step_q == last_step);

  // step table: 0/1 unlock, 2 opcode, 3 target (program) or unlock again (erase)
  always_comb begin
    addr  = '0;
    wdata = '0;
    unique case (step_q)
      3'd0: begin addr = A_KEY1; wdata = KEY_DATA_A; end
      3'd1: begin addr = A_KEY2; wdata = KEY_DATA_B; end
      3'd2: begin addr = A_KEY1; wdata = prog_q ? OPC_BYTE_WRITE : OPC_ERASE_ARM; end
      3'd3: begin
        if (prog_q) begin addr = addr_q; wdata = data_q; end
        else        begin addr = A_KEY1; wdata = KEY_DATA_A; end
      end
      3'd4: begin addr = A_KEY2; wdata = KEY_DATA_B; end
      default: begin addr = '0; wdata = OPC_ERASE_GO; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      prog_q <= 1'b0;
      step_q <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        prog_q <= is_prog;
        step_q <= '0;
        addr_q <= tgt_addr;
        data_q <= tgt_data;
      end
    end else if (step_q == last_step) begin
      busy_q <= 1'b0;
    end else begin
      step_q <= step_q + 3'd1;
    end
  end

endmodule

// File: rtl/flashprog_togglepoll.sv
module flashprog_togglepoll
  import flashprog_pkg::*;
#(
  parameter int POLL_LIMIT = 1000000,
  parameter int CNT_W      = $clog2(POLL_LIMIT + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] rdata,
  output logic       re,
  output logic       done,
  output logic       timed_out
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(POLL_LIMIT);

  phase_e           phase_q;
  logic [7:0]       first_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       diff;
  logic             busy_now;
  logic             at_limit;

  assign diff      = first_q ^ rdata;
  assign busy_now  = diff[TOGGLE_BIT];
  assign at_limit  = (cnt_q == CNT_MAX);
  assign re        = (phase_q == PH_RD1) || (phase_q == PH_RD2);
  assign done      = (phase_q == PH_CMP) && (!busy_now || at_limit);
  assign timed_out = (phase_q == PH_CMP) && busy_now && at_limit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      first_q <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= PH_RD1;
          cnt_q   <= '0;
        end
        PH_RD1:  phase_q <= PH_CAP1;
        PH_CAP1: begin
          first_q <= rdata;
          phase_q <= PH_RD2;
        end
        PH_RD2:  phase_q <= PH_CMP;
        PH_CMP: begin
          if (!busy_now || at_limit) phase_q <= PH_IDLE;
          else begin
            cnt_q   <= cnt_q + 1'b1;
            phase_q <= PH_RD1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flashprog_ctrl.sv
module flashprog_ctrl
  import flashprog_pkg::*;
#(
  parameter int BANK_BYTES = 8192,
  parameter int POLL_LIMIT = 1000000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_valid,
  output logic                          cmd_ready,
  input  logic                          cmd_op,
  input  logic                          img_valid,
  output logic                          img_ready,
  input  logic [7:0]                    img_data,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [1:0]                    rsp_status,
  output logic [$clog2(BANK_BYTES)-1:0] fl_addr,
  output logic [7:0]                    fl_wdata,
  output logic                          fl_we,
  output logic                          fl_re,
  input  logic [7:0]                    fl_rdata
);

  localparam int ADDR_W = $clog2(BANK_BYTES);
  localparam int CNT_W  = $clog2(POLL_LIMIT + 1);
  localparam logic [ADDR_W-1:0] LAST_OFF = ADDR_W'(BANK_BYTES - 1);

  state_e            state_q;
  logic [ADDR_W-1:0] off_q;
  logic [7:0]        data_q;
  status_e           status_q;

  logic              seq_start, seq_prog, seq_we, seq_done;
  logic [ADDR_W-1:0] seq_addr;
  logic [7:0]        seq_wdata;
  logic              poll_start, poll_re, poll_done, poll_to;
  logic              own_re;

  assign cmd_ready  = (state_q == S_IDLE);
  assign img_ready  = (state_q == S_PG_FETCH);
  assign rsp_valid  = (state_q == S_RESP);
  assign rsp_status = status_q;

  assign seq_start  = (cmd_ready && cmd_valid && op_e'(cmd_op) == OP_ERASE)
                    || (img_ready && img_valid);
  assign seq_prog   = img_ready;
  assign poll_start = seq_done && ((state_q == S_ER_CMD) || (state_q == S_PG_CMD));
  assign own_re     = (state_q == S_EV_RD) || (state_q == S_PG_RD);

  assign fl_we    = seq_we;
  assign fl_wdata = seq_wdata;
  assign fl_re    = poll_re || own_re;
  assign fl_addr  = seq_we ? seq_addr : (own_re ? off_q : '0);

  flashprog_cmdseq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (seq_start),
    .is_prog  (seq_prog),
    .tgt_addr (off_q),
    .tgt_data (img_data),
    .we       (seq_we),
    .addr     (seq_addr),
    .wdata    (seq_wdata),
    .done     (seq_done)
  );

  flashprog_togglepoll #(.POLL_LIMIT(POLL_LIMIT), .CNT_W(CNT_W)) u_poll (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (poll_start),
    .rdata     (fl_rdata),
    .re        (poll_re),
    .done      (poll_done),
    .timed_out (poll_to)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      off_q    <= '0;
      data_q   <= '0;
      status_q <= ST_OK;
    end else begin
      unique case (state_q)
        S_IDLE: if (cmd_valid) begin
          off_q   <= '0;
          state_q <= (op_e'(cmd_op) == OP_PROGRAM) ? S_PG_FETCH : S_ER_CMD;
        end
        S_ER_CMD: if (seq_done) state_q <= S_ER_WAIT;
        S_ER_WAIT: if (poll_done) begin
          if (poll_to) begin status_q <= ST_TIMEOUT; state_q <= S_RESP; end
          else state_q <= S_EV_RD;
        end
        S_EV_RD: state_q <= S_EV_CHK;
        S_EV_CHK: begin
          if (fl_rdata != BLANK_BYTE) begin
            status_q <= ST_VERIFY; state_q <= S_RESP;
          end else if (off_q == LAST_OFF) begin
            status_q <= ST_OK; state_q <= S_RESP;
          end else begin
            off_q <= off_q + 1'b1; state_q <= S_EV_RD;
          end
        end
        S_PG_FETCH: if (img_valid) begin
          data_q  <= img_data;
          state_q <= S_PG_CMD;
        end
        S_PG_CMD: if (seq_done) state_q <= S_PG_WAIT;
        S_PG_WAIT: if (poll_done) begin
          if (poll_to) begin status_q <= ST_TIMEOUT; state_q <= S_RESP; end
          else state_q <= S_PG_RD;
        end
        S_PG_RD: state_q <= S_PG_CHK;
        S_PG_CHK: begin
          if (fl_rdata != data_q) begin
            status_q <= ST_VERIFY; state_q <= S_RESP;
          end else if (off_q == LAST_OFF) begin
            status_q <= ST_OK; state_q <= S_RESP;
          end else begin
            off_q <= off_q + 1'b1; state_q <= S_PG_FETCH;
          end
        end
        S_RESP: if (rsp_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flashprog_ctrl_chk.sv
module flashprog_ctrl_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              img_valid,
  input logic              img_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [1:0]        rsp_status,
  input logic [ADDR_W-1:0] fl_addr,
  input logic [7:0]        fl_wdata,
  input logic              fl_we,
  input logic              fl_re
);

  // R5
  read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_re |=> !fl_re);

  // R5
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));

  // R2
  unlock_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we) |-> (fl_addr == ADDR_W'(12'h555)) && (fl_wdata == 8'hAA));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status)));

  // R10
  cmd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R11
  one_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (img_valid && img_ready) |=> !img_ready);

  // R4
  burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (img_valid && img_ready) |=> fl_we);

endmodule

bind flashprog_ctrl flashprog_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .img_valid  (img_valid),
  .img_ready  (img_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_status (rsp_status),
  .fl_addr    (fl_addr),
  .fl_wdata   (fl_wdata),
  .fl_we      (fl_we),
  .fl_re      (fl_re)
);

// File: tb/flashprog_ctrl_bench.sv
`timescale 1ns/1ps
module flashprog_ctrl_bench;

  localparam int BANK   = 2048;
  localparam int AW     = 11;
  localparam int PLIMIT = 40;

  typedef struct packed {
    logic        op;
    logic [3:0]  busy;
    logic        stuck;
    logic [1:0]  fkind;
    logic [15:0] foff;
    logic        stall;
    logic [7:0]  seed;
    logic [1:0]  expst;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{1'b0, 4'd5, 1'b0, 2'd0, 16'd0,    1'b0, 8'h00, 2'd0},
    '{1'b1, 4'd2, 1'b0, 2'd0, 16'd0,    1'b0, 8'h3C, 2'd0},
    '{1'b0, 4'd3, 1'b0, 2'd0, 16'd0,    1'b0, 8'h00, 2'd0},
    '{1'b1, 4'd1, 1'b0, 2'd0, 16'd0,    1'b1, 8'hA7, 2'd0},
    '{1'b0, 4'd1, 1'b1, 2'd0, 16'd0,    1'b0, 8'h00, 2'd1},
    '{1'b1, 4'd1, 1'b1, 2'd0, 16'd0,    1'b0, 8'h11, 2'd1},
    '{1'b0, 4'd1, 1'b0, 2'd1, 16'd2047, 1'b0, 8'h00, 2'd2},
    '{1'b1, 4'd1, 1'b0, 2'd2, 16'd0,    1'b0, 8'h5A, 2'd2}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_op = 1'b0;
  logic          img_valid = 1'b0;
  logic          img_ready;
  logic [7:0]    img_data = 8'h00;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic [1:0]    rsp_status;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_wdata;
  logic          fl_we;
  logic          fl_re;
  logic [7:0]    fl_rdata = 8'h00;

  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  flashprog_ctrl #(.BANK_BYTES(BANK), .POLL_LIMIT(PLIMIT)) u_flashprog_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .img_valid(img_valid), .img_ready(img_ready), .img_data(img_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
    .fl_rdata(fl_rdata)
  );

  function automatic logic [7:0] pat(int i, logic [7:0] s);
    return 8'(i * 37) ^ s ^ 8'(i >> 4);
  endfunction

  // ---------------- flash model ----------------
  logic [7:0] fmem [BANK];
  int   epoch = 0, my_epoch = 0;
  int   cfg_busy = 1;
  bit   cfg_stuck = 0;
  int   cfg_fkind = 0, cfg_foff = 0;
  int   wstep = 0, busy_left = 0, perr = 0, ecount = 0, exp_next = 0;
  int   stuck_reads = 0, wr_count = 0;
  bit   stuck_active = 0, tog = 0, prev_re = 0;

  always @(posedge clk) begin
    if (my_epoch != epoch) begin
      my_epoch = epoch; perr = 0; ecount = 0; exp_next = 0;
      stuck_reads = 0; wr_count = 0; stuck_active = 0; busy_left = 0; wstep = 0;
    end
    if (!rst_n) begin
      wstep = 0; busy_left = 0; stuck_active = 0; prev_re = 0;
    end else begin
      if (fl_we && fl_re) perr++;
      if (fl_re && prev_re) perr++;
      prev_re = fl_re;
      if (fl_we) begin
        wr_count++;
        if (busy_left > 0 || stuck_active) perr++;
        case (wstep)
          0: if (fl_addr == 11'h555 && fl_wdata == 8'hAA) wstep = 1; else begin perr++; wstep = 0; end
          1: if (fl_addr == 11'h2AA && fl_wdata == 8'h55) wstep = 2; else begin perr++; wstep = 0; end
          2: if (fl_addr == 11'h555 && fl_wdata == 8'h80) wstep = 3;
             else if (fl_addr == 11'h555 && fl_wdata == 8'hA0) wstep = 10;
             else begin perr++; wstep = 0; end
          3: if (fl_addr == 11'h555 && fl_wdata == 8'hAA) wstep = 4; else begin perr++; wstep = 0; end
          4: if (fl_addr == 11'h2AA && fl_wdata == 8'h55) wstep = 5; else begin perr++; wstep = 0; end
          5: begin
            if (fl_addr == 11'h000 && fl_wdata == 8'h30) begin
              for (int k = 0; k < BANK; k++) fmem[k] = 8'hFF;
              if (cfg_fkind == 1) fmem[cfg_foff] = 8'h00;
              ecount++;
              busy_left = 2 * cfg_busy;
              stuck_active = cfg_stuck;
            end else perr++;
            wstep = 0;
          end
          10: begin
            if (int'(fl_addr) == exp_next) begin
              fmem[fl_addr] = fmem[fl_addr] & fl_wdata;
              if (cfg_fkind == 2 && int'(fl_addr) == cfg_foff) fmem[fl_addr] = fmem[fl_addr] ^ 8'h01;
              exp_next++;
              busy_left = 2 * cfg_busy;
              stuck_active = cfg_stuck;
            end else perr++;
            wstep = 0;
          end
          default: begin perr++; wstep = 0; end
        endcase
      end
      if (fl_re) begin
        if (busy_left > 0 || stuck_active) begin
          if (fl_addr != '0) perr++;
          fl_rdata <= {1'b0, tog, 6'h00};
          tog = !tog;
          if (stuck_active) stuck_reads++; else busy_left--;
        end else begin
          fl_rdata <= fmem[fl_addr];
        end
      end
    end
  end

  // ---------------- image feeder ----------------
  int   feed_cnt = 0, feed_start = 0, shown_idx = -1;
  bit   feed_en = 0, feed_stall = 0, gapped = 0;
  logic [7:0] feed_seed = 8'h00;

  always @(posedge clk) if (img_valid && img_ready) feed_cnt++;

  always @(negedge clk) begin
    int idx;
    idx = feed_cnt - feed_start;
    if (!feed_en || idx >= BANK) img_valid = 1'b0;
    else if (img_valid && idx == shown_idx) begin end
    else if (feed_stall && (idx % 3 == 0) && !gapped) begin
      img_valid = 1'b0; gapped = 1;
    end else begin
      img_valid = 1'b1; img_data = pat(idx, feed_seed); shown_idx = idx; gapped = 0;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_op(input vec_t vv);
    logic [1:0] st;
    int bad;
    bit held;
    @(negedge clk);
    cfg_busy = int'(vv.busy); cfg_stuck = vv.stuck;
    cfg_fkind = int'(vv.fkind); cfg_foff = int'(vv.foff);
    epoch++;
    feed_seed = vv.seed; feed_stall = vv.stall; feed_start = feed_cnt;
    @(negedge clk);
    feed_en = vv.op;
    cmd_op = vv.op; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b0, "R10 busy after accept", int'(cmd_ready), 0);
    while (!rsp_valid) @(negedge clk);
    feed_en = 0;
    st = rsp_status; held = 1;
    repeat (3) begin
      @(negedge clk);
      if (!rsp_valid || rsp_status != st || cmd_ready) held = 0;
    end
    chk(held, "R10 response held", int'(held), 1);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && cmd_ready, "R10 response taken", int'(rsp_valid), 0);
    if (vv.expst == 2'd1)      chk(st == vv.expst, "R6 timeout status", int'(st), int'(vv.expst));
    else if (vv.expst == 2'd2) chk(st == vv.expst, vv.op ? "R8 program verify" : "R7 erase verify", int'(st), int'(vv.expst));
    else                       chk(st == vv.expst, "R9 ok status", int'(st), int'(vv.expst));
    chk(perr == 0, vv.op ? "R4 R2/R5 program protocol" : "R3 R2/R5 erase protocol", perr, 0);
    if (vv.stuck) chk(stuck_reads == 2 * (PLIMIT + 1), "R6 reads before timeout", stuck_reads, 2 * (PLIMIT + 1));
    if (!vv.op && vv.expst == 2'd0) begin
      chk(ecount == 1, "R3 one erase", ecount, 1);
      bad = 0;
      for (int k = 0; k < BANK; k++) if (fmem[k] != 8'hFF) bad++;
      chk(bad == 0, "R7 bank blank", bad, 0);
    end
    if (vv.op && vv.expst == 2'd0) begin
      chk(exp_next == BANK, "R4 ascending offsets", exp_next, BANK);
      bad = 0;
      for (int k = 0; k < BANK; k++) if (fmem[k] != pat(k, vv.seed)) bad++;
      chk(bad == 0, vv.stall ? "R11 image with gaps" : "R9 image stored", bad, 0);
    end
    if (vv.op && vv.fkind == 2'd2) chk(exp_next == int'(vv.foff) + 1, "R8 stop at mismatch", exp_next, int'(vv.foff) + 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_ready && !rsp_valid && !img_ready && !fl_we && !fl_re, "R1 in reset", int'(cmd_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !rsp_valid && !img_ready && !fl_we && !fl_re, "R1 after reset", int'(cmd_ready), 1);

    for (int v = 0; v < 8; v++) run_op(VECS[v]);

    // starved program, then reset mid-operation
    @(negedge clk);
    epoch++; cfg_stuck = 0; cfg_fkind = 0; cfg_busy = 1;
    @(negedge clk);
    cmd_op = 1'b1; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (30) @(negedge clk);
    chk(wr_count == 0, "R11 no write while starved", wr_count, 0);
    chk(img_ready == 1'b1, "R11 waiting for byte", int'(img_ready), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(cmd_ready && !rsp_valid && !img_ready && !fl_we && !fl_re, "R1 mid-op reset", int'(img_ready), 0);
    rst_n = 1'b1;
    run_op('{1'b0, 4'd1, 1'b0, 2'd0, 16'd0, 1'b0, 8'h00, 2'd0});

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule